// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block watches a set of external interrupt pins and turns each pin event into an interrupt message that carries a vector, a destination and a delivery mode. Each pin owns a 64-bit redirection entry. Software reaches the entry through a small register window. It first writes an index register that picks a pin and a word. It then reads or writes that word through a data register. A read-only version word reports the revision and the pin count. A write-only end-of-interrupt register re-arms level-triggered pins.

Pins pass through a two-flop synchronizer. Each pin can be active high or active low. An edge-triggered pin raises one request per transition into its active level, and an edge that arrives while the pin is masked is lost for good. A level-triggered pin is delivered once and then stays blocked until software writes an end-of-interrupt carrying that pin's vector. When several pins request at once, the lowest-numbered pin is sent first. Messages leave on a valid/ready handshake. Each pin's global interrupt number is a fixed base plus its pin index, and the base is reported on a port.

Top module: `intr_redirect_ctrl`

## Requirements
- R1: After reset no message is valid. Every entry reads low word 0x0001_0000 (only the mask bit set) and high word 0x0000_0000. No edge or level state is pending.
- R2: Register address 2 returns the version word. VERSION is in bits 7:0, NPINS-1 is in bits 23:16, and bits 15:8 and 31:24 are zero.
- R3: Address 0 is the index register. Bit 0 picks the word (0 = low, 1 = high) and bits 8:1 pick the pin. Address 1 reads and writes the selected word. Low-word layout: vector 7:0, delivery mode 10:8, polarity 13 (1 = active low), read-only remote-pending 14, trigger 15 (1 = level), mask 16. In the high word the destination sits in bits 31:16. All other bits read zero. A pin index of NPINS or above ignores writes and reads zero.
- R4: An unmasked edge pin sends exactly one message for each transition into its active level, and the pin's polarity sets that level. The message carries the entry's vector and destination.
- R5: An edge that arrives while the pin is masked is dropped. Clearing the mask afterwards sends no message for it.
- R6: A delivered level pin sets remote-pending and sends nothing more until an end-of-interrupt write (address 3, vector in bits 7:0) matches its vector. A non-matching end-of-interrupt changes nothing. After a matching one, a pin that is still active is delivered again.
- R7: When several pins request at once, the lowest-numbered pin is sent first.
- R8: While msg_valid is high and msg_ready is low, msg_valid and all message fields hold steady.
- R9: The 3-bit delivery mode is forwarded unchanged (fixed 000, lowest priority 001, PMI 010, INIT 101).
- R10: gsi_base equals the GSI_BASE parameter.
- R11: A masked level pin that is held active sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Asynchronous interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 index, 1 data, 2 version, 3 end-of-interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination (processor id in the upper byte, extended id in the lower byte) |
| gsi_base | output | 32 | Global interrupt number of pin 0 |

## Verification
The assertions check four things on every cycle. A masked pin never keeps an edge pending and is never granted. A level pin with remote-pending set is never granted again. A matching end-of-interrupt clears remote-pending. A held message stays frozen under backpressure. Other properties need whole scenarios, so only the bench can show them. These are: a masked edge that stays lost after unmasking, redelivery of a still-active level pin after its end-of-interrupt, lowest-pin ordering between two simultaneous requests, the active-low polarity path, and the field layout seen through the register window.

// File: rtl/irc_pkg.sv
package irc_pkg;

    typedef enum logic [1:0] {
        SEL_INDEX   = 2'd0,
        SEL_WINDOW  = 2'd1,
        SEL_VERSION = 2'd2,
        SEL_EOI     = 2'd3
    } regsel_e;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWPRI = 3'b001;
    localparam logic [2:0] DM_PMI    = 3'b010;
    localparam logic [2:0] DM_INIT   = 3'b101;

    typedef struct packed {
        logic [15:0] dest;
        logic        mask;
        logic        trig;   // 1 = level
        logic        pol;    // 1 = active low
        logic [2:0]  dmode;
        logic [7:0]  vec;
    } rte_t;

    typedef struct packed {
        logic [7:0]  vec;
        logic [2:0]  dmode;
        logic [15:0] dest;
    } msg_t;

    localparam rte_t RTE_RESET = '{dest: 16'h0, mask: 1'b1, trig: 1'b0,
                                   pol: 1'b0, dmode: 3'd0, vec: 8'd0};

    function automatic logic [31:0] low_word(rte_t e, logic pend);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = e.vec;
        w[10:8]  = e.dmode;
        w[13]    = e.pol;
        w[14]    = pend;
        w[15]    = e.trig;
        w[16]    = e.mask;
        return w;
    endfunction

    function automatic msg_t to_msg(rte_t e);
        msg_t m;
        m.vec   = e.vec;
        m.dmode = e.dmode;
        m.dest  = e.dest;
        return m;
    endfunction

endpackage

// File: rtl/irc_pin_front.sv
module irc_pin_front #(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] trig,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] taken,
    output logic [NPINS-1:0] level_act,
    output logic [NPINS-1:0] edge_pend
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic s1, s2, s3;
        logic act, prev_act, edge_hit;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin_in[i];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign act      = s2 ^ pol[i];
        assign prev_act = s3 ^ pol[i];
        assign edge_hit = act & ~prev_act;
        assign level_act[i] = act;

        always_ff @(posedge clk) begin
            if (rst)                   edge_pend[i] <= 1'b0;
            else if (mask[i] || trig[i]) edge_pend[i] <= 1'b0;
            else if (edge_hit)         edge_pend[i] <= 1'b1;
            else if (taken[i])         edge_pend[i] <= 1'b0;
        end

        // R5: a masked pin holds no edge for later delivery
        a_r5_masked_drops: assert property (@(posedge clk) disable iff (rst)
            mask[i] |=> !edge_pend[i]);
    end

endmodule

// File: rtl/irc_entry_table.sv
module irc_entry_table
    import irc_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NPINS-1:0] taken,
    output rte_t             entries [NPINS],
    output logic [NPINS-1:0] irr
);

    localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [8:0]    idx_q;
    logic [7:0]    idx_pin;
    logic          idx_hi, in_range, wr_win, wr_eoi;
    logic [PW-1:0] sel;
    logic          wdata_unused;

    assign idx_pin  = idx_q[8:1];
    assign idx_hi   = idx_q[0];
    assign in_range = (idx_pin <= MAX_PIN);
    assign sel      = idx_pin[PW-1:0];
    assign wr_win   = reg_wr && (regsel_e'(reg_addr) == SEL_WINDOW) && in_range;
    assign wr_eoi   = reg_wr && (regsel_e'(reg_addr) == SEL_EOI);
    assign wdata_unused = ^{reg_wdata[14], reg_wdata[12:11]};

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (reg_wr && (regsel_e'(reg_addr) == SEL_INDEX))
            idx_q <= reg_wdata[8:0];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPINS; i++) begin
            if (rst) begin
                entries[i] <= RTE_RESET;
                irr[i]     <= 1'b0;
            end else begin
                if (wr_win && idx_pin == 8'(i)) begin
                    if (idx_hi) begin
                        entries[i].dest <= reg_wdata[31:16];
                    end else begin
                        entries[i].vec   <= reg_wdata[7:0];
                        entries[i].dmode <= reg_wdata[10:8];
                        entries[i].pol   <= reg_wdata[13];
                        entries[i].trig  <= reg_wdata[15];
                        entries[i].mask  <= reg_wdata[16];
                    end
                end
                if (wr_eoi && reg_wdata[7:0] == entries[i].vec)
                    irr[i] <= 1'b0;
                if (taken[i] && entries[i].trig)
                    irr[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (regsel_e'(reg_addr))
            SEL_INDEX:   reg_rdata = {23'b0, idx_q};
            SEL_WINDOW:  if (in_range)
                             reg_rdata = idx_hi ? {entries[sel].dest, 16'h0}
                                                : low_word(entries[sel], irr[sel]);
            SEL_VERSION: reg_rdata = {8'h0, MAX_PIN, 8'h0, VERSION};
            default:     reg_rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R6: matching end-of-interrupt re-arms a pin not granted in the same cycle
        a_r6_eoi_rearms: assert property (@(posedge clk) disable iff (rst)
            (wr_eoi && reg_wdata[7:0] == entries[i].vec && !taken[i]) |=> !irr[i]);
    end

endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter
    import irc_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] req,
    input  rte_t             entries [NPINS],
    input  logic             msg_ready,
    output logic             msg_valid,
    output msg_t             msg,
    output logic [NPINS-1:0] taken
);

    localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [PW-1:0] pick;
    logic          found, load;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (req[i] && !found) begin
                found = 1'b1;
                pick  = PW'(i);
            end
        end
    end

    assign load  = found && !msg_valid;
    assign taken = load ? (NPINS'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg       <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg       <= to_msg(entries[pick]);
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // R8: message frozen under backpressure
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg)));

    // R7: at most one pin granted per cycle
    a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(taken));

endmodule

// File: rtl/intr_redirect_ctrl.sv
module intr_redirect_ctrl
    import irc_pkg::*;
#(
    parameter int          NPINS    = 24,
    parameter logic [7:0]  VERSION  = 8'h21,
    parameter logic [31:0] GSI_BASE = 32'd48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [7:0]       msg_vector,
    output logic [2:0]       msg_dmode,
    output logic [15:0]      msg_dest,
    output logic [31:0]      gsi_base
);

    rte_t             entries [NPINS];
    logic [NPINS-1:0] irr, taken, req, level_act, edge_pend;
    logic [NPINS-1:0] pol_v, trig_v, mask_v;
    msg_t             msg;

    for (genvar i = 0; i < NPINS; i++) begin : g_vec
        assign pol_v[i]  = entries[i].pol;
        assign trig_v[i] = entries[i].trig;
        assign mask_v[i] = entries[i].mask;
        assign req[i]    = ~mask_v[i] &
                           (edge_pend[i] | (trig_v[i] & level_act[i] & ~irr[i]));
    end

    irc_entry_table #(.NPINS(NPINS), .VERSION(VERSION)) u_table (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .taken    (taken),
        .entries  (entries),
        .irr      (irr)
    );

    irc_pin_front #(.NPINS(NPINS)) u_front (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .pol      (pol_v),
        .trig     (trig_v),
        .mask     (mask_v),
        .taken    (taken),
        .level_act(level_act),
        .edge_pend(edge_pend)
    );

    irc_arbiter #(.NPINS(NPINS)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .entries  (entries),
        .msg_ready(msg_ready),
        .msg_valid(msg_valid),
        .msg      (msg),
        .taken    (taken)
    );

    assign msg_vector = msg.vec;
    assign msg_dmode  = msg.dmode;
    assign msg_dest   = msg.dest;
    assign gsi_base   = GSI_BASE;

    // R11 / R5: a masked pin is never granted
    a_r11_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (taken & mask_v) == '0);

    // R6: a level pin awaiting end-of-interrupt is never granted again
    a_r6_level_blocked: assert property (@(posedge clk) disable iff (rst)
        (taken & irr & trig_v) == '0);

endmodule

// File: tb/sim_intr_redirect_ctrl.sv
module sim_intr_redirect_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          NP         = 24;
    localparam logic [7:0]  VER        = 8'h21;
    localparam logic [31:0] GBASE      = 32'd48;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   pins = '0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            msg_valid;
    logic            msg_ready = 1'b1;
    logic [7:0]      msg_vector;
    logic [2:0]      msg_dmode;
    logic [15:0]     msg_dest;
    logic [31:0]     gsi_base;

    intr_redirect_ctrl #(.NPINS(NP), .VERSION(VER), .GSI_BASE(GBASE)) u0 (
        .clk(clk), .rst(rst), .pin_in(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
        .msg_dest(msg_dest), .gsi_base(gsi_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int ncap   = 0;
    logic [26:0] cap [256];

    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            if (ncap < 256) cap[ncap] = {msg_vector, msg_dmode, msg_dest};
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    function automatic logic [31:0] lowval(input logic [7:0] v, input logic [2:0] dm,
        input logic pol, input logic pend, input logic trig, input logic mask);
        return {15'b0, mask, trig, pend, pol, 2'b00, dm, v};
    endfunction

    task automatic prog(input int pin, input logic [7:0] v, input logic [2:0] dm,
        input logic pol, input logic trig, input logic mask, input logic [15:0] dest);
        wr(2'd0, {23'b0, 8'(pin), 1'b1});
        wr(2'd1, {dest, 16'h0});
        wr(2'd0, {23'b0, 8'(pin), 1'b0});
        wr(2'd1, lowval(v, dm, pol, 1'b0, trig, mask));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        summary();
        $finish;
    end

    initial begin
        int base;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        chk(msg_valid == 1'b0, "R1 valid after reset", 32'(msg_valid), 0);
        wr(2'd0, {23'b0, 8'd0, 1'b0});
        rdchk(2'd1, 32'h0001_0000, "R1 pin0 low word");
        wr(2'd0, {23'b0, 8'd23, 1'b1});
        rdchk(2'd1, 32'h0, "R1 pin23 high word");
        // R2 version word
        rdchk(2'd2, {8'h0, 8'(NP-1), 8'h0, VER}, "R2 version");
        // R10 base
        chk(gsi_base == GBASE, "R10 gsi base", gsi_base, GBASE);

        // R3 window layout and reserved bits
        wr(2'd0, {23'b0, 8'd5, 1'b0});
        rdchk(2'd0, {23'b0, 8'd5, 1'b0}, "R3 index readback");
        wr(2'd1, 32'hFFFF_FFFF);
        rdchk(2'd1, 32'h0001_A7FF, "R3 low word fields");
        wr(2'd0, {23'b0, 8'd5, 1'b1});
        wr(2'd1, 32'hFFFF_FFFF);
        rdchk(2'd1, 32'hFFFF_0000, "R3 high word fields");
        wr(2'd1, 32'h0);
        wr(2'd0, {23'b0, 8'd5, 1'b0});
        wr(2'd1, 32'h0001_0000);
        wr(2'd0, {23'b0, 8'd30, 1'b0});
        wr(2'd1, 32'h0000_00AA);
        rdchk(2'd1, 32'h0, "R3 out-of-range index");

        // R5 masked edge dropped
        prog(1, 8'h11, 3'b101, 1'b0, 1'b0, 1'b1, 16'hABCD);
        base = ncap;
        pins[1] = 1'b1; step(3); pins[1] = 1'b0; step(10);
        chk(ncap == base, "R5 masked edge", 32'(ncap - base), 0);
        wr(2'd1, lowval(8'h11, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0));
        step(10);
        chk(ncap == base, "R5 no delayed message after unmask", 32'(ncap - base), 0);
        // R4 / R9 edge delivery with INIT mode
        pins[1] = 1'b1; step(3); pins[1] = 1'b0; step(10);
        chk(ncap == base + 1, "R4 edge count", 32'(ncap - base), 1);
        chk(cap[base] == {8'h11, 3'b101, 16'hABCD}, "R9 INIT fields", 32'(cap[base]),
            32'({8'h11, 3'b101, 16'hABCD}));

        // R4 active-low pin
        pins[6] = 1'b1;
        prog(6, 8'h66, 3'b000, 1'b1, 1'b0, 1'b0, 16'h0102);
        step(4);
        base = ncap;
        pins[6] = 1'b0; step(3); pins[6] = 1'b1; step(10);
        chk(ncap == base + 1, "R4 active-low edge count", 32'(ncap - base), 1);
        chk(cap[base] == {8'h66, 3'b000, 16'h0102}, "R4 active-low fields", 32'(cap[base]),
            32'({8'h66, 3'b000, 16'h0102}));

        // R6 level with end-of-interrupt
        prog(2, 8'h40, 3'b001, 1'b0, 1'b1, 1'b0, 16'h0203);
        base = ncap;
        pins[2] = 1'b1; step(12);
        chk(ncap == base + 1, "R6 level single delivery", 32'(ncap - base), 1);
        wr(2'd0, {23'b0, 8'd2, 1'b0});
        rdchk(2'd1, lowval(8'h40, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0), "R6 pending bit set");
        wr(2'd3, 32'h41); step(10);
        chk(ncap == base + 1, "R6 wrong vector ignored", 32'(ncap - base), 1);
        wr(2'd3, 32'h40); step(10);
        chk(ncap == base + 2, "R6 redelivery after eoi", 32'(ncap - base), 2);
        pins[2] = 1'b0; step(4);
        wr(2'd3, 32'h40); step(10);
        chk(ncap == base + 2, "R6 inactive pin silent after eoi", 32'(ncap - base), 2);
        rdchk(2'd1, lowval(8'h40, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0), "R6 pending bit cleared");

        // R11 masked level pin
        prog(4, 8'h44, 3'b000, 1'b0, 1'b1, 1'b1, 16'h0);
        base = ncap;
        pins[4] = 1'b1; step(12);
        chk(ncap == base, "R11 masked level", 32'(ncap - base), 0);
        pins[4] = 1'b0;

        // R7 priority and R8 hold
        msg_ready = 1'b0;
        prog(5, 8'h35, 3'b010, 1'b0, 1'b1, 1'b0, 16'h0505);
        prog(3, 8'h33, 3'b000, 1'b0, 1'b1, 1'b0, 16'h0303);
        base = ncap;
        pins[3] = 1'b1; pins[5] = 1'b1;
        step(8);
        chk(msg_valid && msg_vector == 8'h33, "R7 lowest pin first", 32'(msg_vector), 32'h33);
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk(msg_valid && msg_vector == 8'h33 && msg_dest == 16'h0303 && msg_dmode == 3'b000,
                "R8 held message stable", {msg_vector, msg_dmode, 5'b0, msg_dest}, 32'h3300_0303);
        end
        msg_ready = 1'b1;
        step(10);
        chk(ncap == base + 2, "R7 both delivered", 32'(ncap - base), 2);
        chk(cap[base + 1] == {8'h35, 3'b010, 16'h0505}, "R9 PMI second message",
            32'(cap[base + 1]), 32'({8'h35, 3'b010, 16'h0505}));
        pins[3] = 1'b0; pins[5] = 1'b0;
        step(4);
        wr(2'd3, 32'h33); wr(2'd3, 32'h35);

        // R4 / R9 random edge traffic
        for (int it = 0; it < 24; it++) begin
            int p;
            logic [7:0]  v;
            logic [2:0]  dm;
            logic [15:0] d;
            logic        pl;
            logic [2:0]  modes [4];
            modes[0] = 3'b000; modes[1] = 3'b001; modes[2] = 3'b010; modes[3] = 3'b101;
            p  = 8 + int'($urandom % 8);
            v  = 8'($urandom);
            dm = modes[$urandom % 4];
            d  = 16'($urandom);
            pl = 1'($urandom);
            pins[p] = pl;
            prog(p, v, dm, pl, 1'b0, 1'b0, d);
            step(4);
            base = ncap;
            pins[p] = ~pl; step(3); pins[p] = pl; step(12);
            chk(ncap == base + 1, "R4 random edge count", 32'(ncap - base), 1);
            chk(cap[base] == {v, dm, d}, "R9 random fields", 32'(cap[base]), 32'({v, dm, d}));
            wr(2'd0, {23'b0, 8'(p), 1'b0});
            wr(2'd1, lowval(v, dm, pl, 1'b0, 1'b0, 1'b1));
        end

        summary();
        $finish;
    end

endmodule